// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a processor domain from three sources: a power-good level, an active-low pushbutton and a watchdog strobe. It drives an active-high reset and an active-low reset. The two outputs are exact complements of each other. Every reset event keeps the outputs asserted for at least a stretch period. The block counts that period, the debounce interval and the watchdog timeouts in cycles of `clk_i`. All of them are parameters, so a simulation can use short values and silicon can use the real ones.

Power-good low forces reset at once, with no clock needed. Once power-good rises, reset is held for one full stretch period. A pushbutton press is synchronized and debounced. Reset stays asserted for as long as the debounced button is held. The stretch period starts only when the debounced button is released.

The watchdog cannot be switched off. It counts only while reset is inactive. A falling edge on the synchronized strobe reloads the count. If the count reaches the selected timeout, reset is asserted for a full stretch period. The watchdog then starts again when reset ends. A 2-bit select picks one of three timeouts.

Top module: `rstsup_top`

## Requirements
- R1: While `pwr_good_i` is low, `rst_o` is 1 and `rst_no` is 0. A fall of `pwr_good_i` asserts both outputs immediately, without waiting for a clock edge.
- R2: After `pwr_good_i` rises, with no other source active, reset deasserts on exactly the STRETCH_CYC-th rising clock edge.
- R3: `rst_no` is always the complement of `rst_o`.
- R4: `btn_ni` passes through a two-stage synchronizer and a debouncer. A low level that lasts fewer than DEBOUNCE_CYC clocks has no effect on reset.
- R5: A held press asserts reset on the (3+DEBOUNCE_CYC)-th edge after the press and keeps it asserted while the button is held. After release, reset deasserts on the (2+DEBOUNCE_CYC+STRETCH_CYC)-th edge.
- R6: `wd_sel_i` picks the timeout T: 2'b00 gives WD_SHORT_CYC, 2'b01 and 2'b11 give WD_MID_CYC, and 2'b10 gives WD_LONG_CYC. With no strobe fall, reset reasserts on the T-th edge after the edge at which it deasserted.
- R7: A 1-to-0 transition of `strobe_i` while reset is inactive reloads the watchdog. Reset then reasserts on the (3+T)-th edge after the transition, unless another fall comes first.
- R8: A rising edge or a steady level of `strobe_i` does not reload the watchdog.
- R9: A watchdog timeout asserts reset for exactly STRETCH_CYC edges. The watchdog does not count while reset is asserted and restarts when reset ends.
- R10: A press that arrives during a stretch period makes the stretch start again from its full length, counted from that press's release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| pwr_good_i | input | 1 | Supply-good level; low means fault and acts as the asynchronous reset |
| btn_ni | input | 1 | Pushbutton, active low, asynchronous |
| strobe_i | input | 1 | Watchdog strobe, asynchronous; a falling edge reloads the watchdog |
| wd_sel_i | input | 2 | Watchdog timeout select |
| rst_o | output | 1 | Reset, active high, registered |
| rst_no | output | 1 | Reset, active low, registered complement of `rst_o` |

## Verification
The assertions assume that `wd_sel_i` changes only while reset is asserted. A change to a shorter setting while the watchdog is counting could leave the count above the new limit for one cycle. The assertions also assume that `pwr_good_i` changes away from the clock edge. The stimulus follows both rules: it moves the select only during a reset pulse, and it drives every input on the falling clock edge. Random strobe gaps are drawn so that the interval between two falls stays well inside the shortest timeout.

// File: rtl/rstsup_pkg.sv
`timescale 1ns/1ps
package rstsup_pkg;

   typedef enum logic [1:0] {
      WD_SEL_SHORT = 2'b00,
      WD_SEL_MID   = 2'b01,
      WD_SEL_LONG  = 2'b10,
      WD_SEL_MID2  = 2'b11
   } wd_sel_e;

   // Timeout length in clocks for a select code; the code 11 maps to the middle setting.
   function automatic int unsigned wd_timeout(input logic [1:0] sel,
                                              input int unsigned t_short,
                                              input int unsigned t_mid,
                                              input int unsigned t_long);
      case (wd_sel_e'(sel))
         WD_SEL_SHORT: return t_short;
         WD_SEL_LONG:  return t_long;
         default:      return t_mid;
      endcase
   endfunction

endpackage

// File: rtl/rstsup_sync.sv
`timescale 1ns/1ps
module rstsup_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstsup_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ff_q[i] <= RST_VAL;
            end else begin
               if (i == 0) ff_q[i] <= d_i;
               else        ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/rstsup_debounce.sv
`timescale 1ns/1ps
module rstsup_debounce #(
   parameter int unsigned STABLE_CYC = 10000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   output logic stable_o
);

   localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);

   generate
      if (STABLE_CYC < 2) begin : g_bad_cyc
         $error("rstsup_debounce: STABLE_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          stable_q;
   logic          differ;

   assign differ = (level_i != stable_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stable_q <= 1'b1;
         cnt_q    <= '0;
      end else if (!differ) begin
         cnt_q    <= '0;
      end else if (cnt_q == CW'(STABLE_CYC-1)) begin
         stable_q <= level_i;
         cnt_q    <= '0;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign stable_o = stable_q;

   // R4: the filtered level moves only after a full run of mismatching samples
   p_db_full_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(stable_q) |-> $past(cnt_q) == CW'(STABLE_CYC-1));

   // R4: the counter never runs past its limit
   p_db_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(STABLE_CYC-1));

endmodule

// File: rtl/rstsup_wdog.sv
`timescale 1ns/1ps
module rstsup_wdog
   import rstsup_pkg::*;
#(
   parameter int unsigned T_SHORT = 62500,
   parameter int unsigned T_MID   = 250000,
   parameter int unsigned T_LONG  = 500000
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       hold_i,
   input  logic       kick_i,
   input  logic [1:0] sel_i,
   output logic       expire_o
);

   localparam int unsigned TMAX_A = (T_SHORT > T_MID) ? T_SHORT : T_MID;
   localparam int unsigned TMAX   = (TMAX_A > T_LONG) ? TMAX_A : T_LONG;
   localparam int unsigned CW     = $clog2(TMAX + 1);

   generate
      if (T_SHORT < 2 || T_MID < 2 || T_LONG < 2) begin : g_bad_timeout
         $error("rstsup_wdog: every timeout must be at least 2 clocks");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit_m1;
   logic          kick_prev_q;
   logic          kick_fall;

   assign limit_m1  = CW'(wd_timeout(sel_i, T_SHORT, T_MID, T_LONG) - 1);
   assign kick_fall = kick_prev_q & ~kick_i;
   assign expire_o  = ~hold_i & ~kick_fall & (cnt_q >= limit_m1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q       <= '0;
         kick_prev_q <= 1'b0;
      end else begin
         kick_prev_q <= kick_i;
         if (hold_i || kick_fall || expire_o) cnt_q <= '0;
         else                                 cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: with the select steady, the count stays below the chosen timeout
   p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= limit_m1);

   // R7: a falling strobe edge while reset is inactive starts a fresh period
   p_kick_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kick_fall && !hold_i) |=> (cnt_q == '0) && !expire_o);

   // R9: the watchdog is frozen while reset is asserted
   p_frozen_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> cnt_q == '0);

endmodule

// File: rtl/rstsup_top.sv
`timescale 1ns/1ps
module rstsup_top #(
   parameter int unsigned STRETCH_CYC  = 250000,
   parameter int unsigned DEBOUNCE_CYC = 10000,
   parameter int unsigned WD_SHORT_CYC = 62500,
   parameter int unsigned WD_MID_CYC   = 250000,
   parameter int unsigned WD_LONG_CYC  = 500000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk_i,
   input  logic       pwr_good_i,
   input  logic       btn_ni,
   input  logic       strobe_i,
   input  logic [1:0] wd_sel_i,
   output logic       rst_o,
   output logic       rst_no
);

   localparam int unsigned SCW = (STRETCH_CYC < 2) ? 1 : $clog2(STRETCH_CYC);

   generate
      if (STRETCH_CYC < 2) begin : g_bad_stretch
         $error("rstsup_top: STRETCH_CYC must be at least 2");
      end
   endgenerate

   logic           btn_s;
   logic           stb_s;
   logic           btn_db;
   logic           wd_expire;
   logic           rst_q;
   logic           rstn_q;
   logic [SCW-1:0] st_cnt_q;
   logic           src_active;

   rstsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
      .clk_i(clk_i), .rst_ni(pwr_good_i), .d_i(btn_ni), .q_o(btn_s));

   rstsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stb_sync (
      .clk_i(clk_i), .rst_ni(pwr_good_i), .d_i(strobe_i), .q_o(stb_s));

   rstsup_debounce #(.STABLE_CYC(DEBOUNCE_CYC)) u_btn_db (
      .clk_i(clk_i), .rst_ni(pwr_good_i), .level_i(btn_s), .stable_o(btn_db));

   rstsup_wdog #(.T_SHORT(WD_SHORT_CYC), .T_MID(WD_MID_CYC), .T_LONG(WD_LONG_CYC)) u_wdog (
      .clk_i(clk_i), .rst_ni(pwr_good_i), .hold_i(rst_q), .kick_i(stb_s),
      .sel_i(wd_sel_i), .expire_o(wd_expire));

   assign src_active = ~btn_db | wd_expire;

   always_ff @(posedge clk_i or negedge pwr_good_i) begin
      if (!pwr_good_i) begin
         rst_q    <= 1'b1;
         rstn_q   <= 1'b0;
         st_cnt_q <= '0;
      end else if (src_active) begin
         rst_q    <= 1'b1;
         rstn_q   <= 1'b0;
         st_cnt_q <= '0;
      end else if (rst_q) begin
         if (st_cnt_q == SCW'(STRETCH_CYC-1)) begin
            rst_q    <= 1'b0;
            rstn_q   <= 1'b1;
            st_cnt_q <= '0;
         end else begin
            st_cnt_q <= st_cnt_q + 1'b1;
         end
      end
   end

   assign rst_o  = rst_q;
   assign rst_no = rstn_q;

   // R3: the two registered outputs never agree
   p_complement_r3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      rst_o != rst_no);

   // R2: release only at the end of a full stretch count
   p_stretch_len_r2: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      $fell(rst_q) |-> $past(st_cnt_q) == SCW'(STRETCH_CYC-1));

   // R5: a held debounced press keeps reset asserted
   p_btn_hold_r5: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      !btn_db |=> rst_o && !rst_no);

   // R9: a watchdog expiry asserts reset on the next edge
   p_expire_asserts_r9: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      wd_expire |=> rst_o);

endmodule

// File: tb/rstsup_top_tb_top.sv
`timescale 1ns/1ps
module rstsup_top_tb_top;

   localparam int unsigned S  = 40;
   localparam int unsigned DB = 8;
   localparam int unsigned TS = 60;
   localparam int unsigned TM = 120;
   localparam int unsigned TL = 200;

   logic       clk = 1'b0;
   logic       pwr_good = 1'b0;
   logic       btn_n = 1'b1;
   logic       strobe = 1'b0;
   logic [1:0] wd_sel = 2'b00;
   logic       rst_o;
   logic       rst_no;

   int checks = 0;
   int fails  = 0;
   int comp_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rstsup_top #(
      .STRETCH_CYC(S), .DEBOUNCE_CYC(DB),
      .WD_SHORT_CYC(TS), .WD_MID_CYC(TM), .WD_LONG_CYC(TL), .SYNC_STAGES(2)
   ) dut_i (
      .clk_i(clk), .pwr_good_i(pwr_good), .btn_ni(btn_n), .strobe_i(strobe),
      .wd_sel_i(wd_sel), .rst_o(rst_o), .rst_no(rst_no));

   function automatic int unsigned exp_timeout(input logic [1:0] s);
      case (s)
         2'b00:   return TS;
         2'b10:   return TL;
         default: return TM;
      endcase
   endfunction

   always @(negedge clk) if (rst_o === rst_no) comp_err++;

   task automatic edges(input int unsigned n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: rst_o actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic expect_rise(input int unsigned n, input string req);
      edges(n - 1);
      check(req, rst_o, 1'b0);
      edges(1);
      check(req, rst_o, 1'b1);
   endtask

   task automatic expect_fall(input int unsigned n, input string req);
      edges(n - 1);
      check(req, rst_o, 1'b1);
      edges(1);
      check(req, rst_o, 1'b0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned elapsed;
      int unsigned half;
      int unsigned rnd_err;
      bit          seen;
      void'($urandom(32'd20240611));

      @(negedge clk);
      edges(3);
      check("R1 reset state", rst_o, 1'b1);
      check("R1 reset state rst_no", rst_no, 1'b0);

      // R2: power-up hold
      pwr_good = 1'b1;
      expect_fall(S, "R2 power-up stretch");

      // R6 short timeout and R9 pulse length and restart
      expect_rise(exp_timeout(2'b00), "R6 sel=00 timeout");
      expect_fall(S, "R9 watchdog pulse length");
      expect_rise(exp_timeout(2'b00), "R9 watchdog restart after reset");

      for (int k = 1; k < 4; k++) begin
         edges(S - 1);
         check("R9 pulse still active", rst_o, 1'b1);
         wd_sel = 2'(k);
         edges(1);
         check("R9 pulse end", rst_o, 1'b0);
         expect_rise(exp_timeout(2'(k)), "R6 select decode timeout");
      end

      wd_sel = 2'b00;
      expect_fall(S, "R9 pulse");

      // R8: a rising strobe edge does not reload
      edges(10);
      strobe = 1'b1;
      expect_rise(exp_timeout(2'b00) - 10, "R8 rising strobe ignored");
      strobe = 1'b0;
      expect_fall(S, "R9 pulse");

      // R7: a falling strobe edge reloads
      edges(30);
      strobe = 1'b1;
      edges(5);
      strobe = 1'b0;
      expect_rise(3 + exp_timeout(2'b00), "R7 falling strobe reload");
      expect_fall(S, "R9 pulse");

      // R7: random kicking keeps reset away
      rnd_err = 0;
      elapsed = 0;
      while (elapsed < 600) begin
         half = 2 + ($urandom % 23);
         strobe = ~strobe;
         for (int c = 0; c < int'(half); c++) begin
            edges(1);
            if (rst_o !== 1'b0) rnd_err++;
         end
         elapsed += half;
      end
      checks++;
      if (rnd_err != 0) begin
         fails++;
         $display("FAIL R7 random kicking: reset cycles actual=%0d expected=0", rnd_err);
      end

      // After the kicks stop, the watchdog must expire
      seen = 1'b0;
      for (int c = 0; c < int'(TS) + 10 && !seen; c++) begin
         edges(1);
         if (rst_o === 1'b1) seen = 1'b1;
      end
      checks++;
      if (!seen) begin
         fails++;
         $display("FAIL R7 expiry after kicks stop: actual=no reset expected=reset");
      end
      wd_sel = 2'b10;
      strobe = 1'b0;
      expect_fall(S, "R9 pulse");

      // R4: short glitch ignored
      btn_n = 1'b0;
      edges(DB / 2);
      btn_n = 1'b1;
      edges(20);
      check("R4 short press ignored", rst_o, 1'b0);

      // R5: hold and release
      btn_n = 1'b0;
      expect_rise(3 + DB, "R5 press asserts");
      edges(100);
      check("R5 held press keeps reset", rst_o, 1'b1);
      btn_n = 1'b1;
      edges(20);
      check("R5 stretch after release", rst_o, 1'b1);

      // R10: new press during the stretch restarts it
      btn_n = 1'b0;
      edges(20);
      btn_n = 1'b1;
      expect_fall(2 + DB + S, "R10 stretch restart after second release");

      // R1: power-good loss is immediate
      edges(30);
      pwr_good = 1'b0;
      #1;
      check("R1 async assert", rst_o, 1'b1);
      check("R1 async assert rst_no", rst_no, 1'b0);
      edges(5);
      pwr_good = 1'b1;
      expect_fall(S, "R2 stretch after power-good returns");

      checks++;
      if (comp_err != 0) begin
         fails++;
         $display("FAIL R3 complement: mismatches actual=%0d expected=0", comp_err);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule